// File: doc/BRIEF.md
# Emulation Takeover Mode Detector

This block decides, once per reset, whether the microcontroller should hand its pins over to an external emulator or test processor. Two strap pins, the address-latch strobe (ALE) and the program-store enable (PSEN), are synchronised to the clock together with the device reset pin. At the moment the synchronised reset falls, the strap values from the last cycle in which reset was still seen asserted decide the mode. Entry needs ALE low and PSEN high. Any other combination leaves the device in normal operation.

While the mode is active, the block asks the pad ring to float every port 0 pin. It asks for weak pull-ups on the other port pins and on the ALE and PSEN pins. It withholds the internal processor's permission to drive pins, and it keeps the oscillator enabled. The mode persists until a later reset is released without the strap condition. All pins are plain control levels. No data moves through the block, so it has no valid/ready interface and no back-pressure.

Top module: `emu_entry_detect`

## Requirements
- R1: After power-on reset (por_n low), emu_active_o is 0, every bit of p0_float_o and weak_pu_o is 0, cpu_drive_en_o is 1 and osc_keep_o is 0.
- R2: If ALE is low (0) and PSEN is high (1) on the last synchronised cycle in which reset is seen asserted, releasing rst_pin (1 to 0) turns emu_active_o on. This holds even when ALE rises in the same cycle that rst_pin falls.
- R3: If ALE is high on that last sampled cycle, the mode is not entered, even if ALE was low earlier in the reset.
- R4: If PSEN is low on that last sampled cycle, the mode is not entered.
- R5: While the mode is active, every bit of p0_float_o is 1.
- R6: While the mode is active, every bit of weak_pu_o is 1. The low P_OTHER*PORT_W bits cover ports 1 and up, the next bit covers ALE and the top bit covers PSEN.
- R7: While the mode is active, osc_keep_o is 1.
- R8: While the mode is active, cpu_drive_en_o is 0. Otherwise it is 1.
- R9: The mode changes only at a reset release. It is held while rst_pin is asserted. A release without the strap condition clears it. Strap changes outside reset have no effect.
- R10: After rst_pin falls, emu_active_o takes its new value on the (SYNC_STAGES+1)th rising clock edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Device reset pin, active high, asynchronous to clk |
| ale_pin | input | 1 | ALE strap level, asynchronous |
| psen_pin | input | 1 | PSEN strap level, asynchronous |
| emu_active_o | output | 1 | Emulation takeover mode is active |
| p0_float_o | output | P0_W (8) | Per-pin float enable for port 0 |
| weak_pu_o | output | P_OTHER*PORT_W+2 (26) | Weak pull-up enables: other ports, then ALE, then PSEN |
| cpu_drive_en_o | output | 1 | Internal processor may drive pins |
| osc_keep_o | output | 1 | Force the oscillator to stay enabled |

## Verification
The bench sweeps every combination of early ALE level, final ALE level and final PSEN level within a reset, starting once from normal mode and once from the active mode. This separates "last sample decides" from "any sample decides", and it shows both entry into the mode and exit from it. A case in which ALE rises in the same cycle that reset falls pins down which cycle counts as the last sample. Each release is also checked one cycle before its expected effect, which exposes a wrong synchroniser depth. Toggling the straps while the mode is active and reset is idle shows that they are ignored outside reset.

// File: rtl/emu_entry_pkg.sv
package emu_entry_pkg;
  typedef struct packed {
    logic rst;
    logic ale;
    logic psen;
  } strap_t;

  localparam strap_t STRAP_IDLE = '{rst: 1'b1, ale: 1'b1, psen: 1'b0};
endpackage

// File: rtl/emu_sync.sv
module emu_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] r;
      always_ff @(posedge clk or negedge por_n)
        if (!por_n) r <= RST_VAL;
        else        r <= d;
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain;
      always_ff @(posedge clk or negedge por_n)
        if (!por_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/emu_mode_latch.sv
module emu_mode_latch (
  input  logic clk,
  input  logic por_n,
  input  logic rst_s,
  input  logic ale_s,
  input  logic psen_s,
  output logic active
);
  logic rst_q;
  logic qual_q;
  logic release_now;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      rst_q  <= 1'b1;
      qual_q <= 1'b0;
    end else begin
      rst_q  <= rst_s;
      qual_q <= rst_s & ~ale_s & psen_s;
    end

  assign release_now = rst_q & ~rst_s;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)           active <= 1'b0;
    else if (release_now) active <= qual_q;

  a_r2_entry: assert property (@(posedge clk) disable iff (!por_n)
    release_now && qual_q |=> active);
  a_r3_no_entry: assert property (@(posedge clk) disable iff (!por_n)
    release_now && !qual_q |=> !active);
  a_r9_hold: assert property (@(posedge clk) disable iff (!por_n)
    !release_now |=> $stable(active));
endmodule

// File: rtl/emu_pin_ctrl.sv
module emu_pin_ctrl #(
  parameter int P0_W = 8,
  parameter int WPU_W = 26
) (
  input  logic             active,
  output logic [P0_W-1:0]  p0_float,
  output logic [WPU_W-1:0] weak_pu,
  output logic             cpu_drive_en,
  output logic             osc_keep
);
  for (genvar i = 0; i < P0_W; i++) begin : g_p0
    assign p0_float[i] = active;
  end
  for (genvar j = 0; j < WPU_W; j++) begin : g_wpu
    assign weak_pu[j] = active;
  end
  assign cpu_drive_en = ~active;
  assign osc_keep     = active;
endmodule

// File: rtl/emu_entry_detect.sv
module emu_entry_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int P0_W = 8,
  parameter int P_OTHER = 3,
  parameter int PORT_W = 8,
  localparam int WPU_W = P_OTHER * PORT_W + 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_pin,
  input  logic             ale_pin,
  input  logic             psen_pin,
  output logic             emu_active_o,
  output logic [P0_W-1:0]  p0_float_o,
  output logic [WPU_W-1:0] weak_pu_o,
  output logic             cpu_drive_en_o,
  output logic             osc_keep_o
);
  import emu_entry_pkg::*;

  strap_t raw, synced;
  assign raw = '{rst: rst_pin, ale: ale_pin, psen: psen_pin};

  emu_sync #(.STAGES(SYNC_STAGES), .WIDTH($bits(strap_t)), .RST_VAL(STRAP_IDLE)) u_sync (
    .clk(clk), .por_n(por_n), .d(raw), .q(synced)
  );

  emu_mode_latch u_latch (
    .clk(clk), .por_n(por_n), .rst_s(synced.rst), .ale_s(synced.ale),
    .psen_s(synced.psen), .active(emu_active_o)
  );

  emu_pin_ctrl #(.P0_W(P0_W), .WPU_W(WPU_W)) u_pins (
    .active(emu_active_o), .p0_float(p0_float_o), .weak_pu(weak_pu_o),
    .cpu_drive_en(cpu_drive_en_o), .osc_keep(osc_keep_o)
  );

  a_r5_p0_float: assert property (@(posedge clk) disable iff (!por_n)
    emu_active_o |-> &p0_float_o);
  a_r6_weak_pu: assert property (@(posedge clk) disable iff (!por_n)
    emu_active_o |-> &weak_pu_o);
  a_r7_osc: assert property (@(posedge clk) disable iff (!por_n)
    emu_active_o |-> osc_keep_o);
  a_r8_cpu_hold: assert property (@(posedge clk) disable iff (!por_n)
    emu_active_o |-> !cpu_drive_en_o);
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!por_n)
    !emu_active_o |-> (p0_float_o == '0) && (weak_pu_o == '0) && cpu_drive_en_o);
endmodule

// File: tb/emu_entry_detect_test.sv
module emu_entry_detect_test;
  localparam int S = 2;
  localparam int P0_W = 8;
  localparam int WPU_W = 3 * 8 + 2;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin = 1'b1, ale_pin = 1'b1, psen_pin = 1'b0;
  logic emu_active_o, cpu_drive_en_o, osc_keep_o;
  logic [P0_W-1:0] p0_float_o;
  logic [WPU_W-1:0] weak_pu_o;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  emu_entry_detect #(.SYNC_STAGES(S), .P0_W(P0_W), .P_OTHER(3), .PORT_W(8)) uut (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .ale_pin(ale_pin), .psen_pin(psen_pin),
    .emu_active_o(emu_active_o), .p0_float_o(p0_float_o), .weak_pu_o(weak_pu_o),
    .cpu_drive_en_o(cpu_drive_en_o), .osc_keep_o(osc_keep_o)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Checks every output against the mode expected (R1, R5, R6, R7, R8).
  task automatic chk_all(input logic exp, input string tag);
    chk(64'(emu_active_o), 64'(exp), {tag, " active"});
    chk(64'(p0_float_o), exp ? 64'({P0_W{1'b1}}) : 64'd0, {tag, " R5 p0_float"});
    chk(64'(weak_pu_o), exp ? 64'({WPU_W{1'b1}}) : 64'd0, {tag, " R6 weak_pu"});
    chk(64'(osc_keep_o), 64'(exp), {tag, " R7 osc_keep"});
    chk(64'(cpu_drive_en_o), 64'(!exp), {tag, " R8 cpu_drive_en"});
  endtask

  // One reset cycle: early strap levels, then final levels for one cycle, then release.
  task automatic reset_cycle(input logic ale_e, input logic psen_e, input logic ale_l,
                             input logic psen_l, input logic prev, input string tag);
    logic exp_new;
    exp_new = !ale_l && psen_l;
    @(negedge clk); rst_pin = 1'b1; ale_pin = ale_e; psen_pin = psen_e;
    repeat (6) @(negedge clk);
    chk(64'(emu_active_o), 64'(prev), {tag, " R9 held in reset"});
    ale_pin = ale_l; psen_pin = psen_l;
    @(negedge clk); rst_pin = 1'b0;
    repeat (S) @(negedge clk);
    chk(64'(emu_active_o), 64'(prev), {tag, " R10 not yet"});
    @(negedge clk);
    chk_all(exp_new, {tag, " R2 R3 R4 decision"});
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all(1'b0, "R1 reset state");
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all(1'b0, "R1 after por");

    for (int prev = 0; prev < 2; prev++) begin
      for (int c = 0; c < 8; c++) begin
        // Put the block into the starting mode first.
        reset_cycle(1'b0, 1'b1, !prev[0], 1'b1, emu_active_o, "setup");
        reset_cycle(c[2], 1'b1, c[1], c[0], prev[0],
                    $sformatf("sweep prev=%0d ale_e=%0d ale_l=%0d psen_l=%0d",
                              prev, c[2], c[1], c[0]));
      end
    end

    // R2 boundary: ALE rises in the same cycle as the reset release.
    reset_cycle(1'b1, 1'b1, 1'b1, 1'b1, emu_active_o, "clear");
    @(negedge clk); rst_pin = 1'b1; ale_pin = 1'b0; psen_pin = 1'b1;
    repeat (6) @(negedge clk);
    rst_pin = 1'b0; ale_pin = 1'b1;
    repeat (S + 1) @(negedge clk);
    chk_all(1'b1, "R2 ALE rises with release");

    // R3 boundary: ALE rises one cycle before release.
    reset_cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R3 ALE high one cycle early");

    // R9: enter the mode, then toggle straps outside reset.
    reset_cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R9 enter");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ale_pin = k[0]; psen_pin = k[1];
      repeat (S + 2) @(negedge clk);
      chk_all(1'b1, "R9 straps ignored outside reset");
    end

    // R9: exit through a reset without the strap condition.
    reset_cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R9 exit");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule